// File: doc/BRIEF.md
# Message-Signalled Interrupt Aggregator

This block gathers eleven interrupt request lines into one upstream interrupt, delivered as a posted memory write. The write carries an address and a small vector word. Both come from a single programmed target register. Each input line passes through a two-flop synchroniser. A rising edge on a synchronised line is latched as a pending event. If the line is enabled and delivery is switched on, that edge also queues one upstream write.

A host port with single-cycle register accesses controls the block. Reads return data one cycle later. Software acknowledges by reading. A read of the request register returns the enabled pending events and clears them. A read of the pending register returns and clears every pending event. A live-level register shows the synchronised line states at all times, so a handler can see that a line is still asserted after it has been acknowledged. This lets software emulate level-triggered behaviour on top of edge-based delivery.

Only one upstream write is outstanding at a time. After a write has been sent, the block sends no further write until the host reads the request register. Edges that arrive in the meantime merge into the pending state.

Top module: `msi_agg`

## Requirements
- R1: After reset, every register reads zero and `up_valid_o` is low.
- R2: The target register at offset 0x004 stores all 32 bits. The mask register at 0x018 stores only the implemented bits (implemented set 0x5FF, so line 9 is absent). Control at 0x024 stores bit 0, which enables delivery; its other bits read zero.
- R3: The live register at 0x028 returns the synchronised level of all 11 lines, including line 9, whatever the mask holds. Reading it changes nothing.
- R4: A rising edge on an implemented line sets that line's bit in the pending register at 0x01C, whether or not the line is masked. Line 9 never sets a bit.
- R5: A read of the request register at 0x00C returns pending AND mask, and clears only those bits. Pending bits of masked-off lines survive.
- R6: A read of the pending register returns all pending bits and clears them all. The live register is unaffected.
- R7: With delivery enabled and no write outstanding, an enabled edge produces exactly one upstream write. Its address is the target with bits 4:0 cleared, and its data is target bits 4:0, zero-extended. A line held high produces no further write.
- R8: Once raised, `up_valid_o` stays high until `up_ready_i` is seen. Address and data hold steady meanwhile, even if the target register is rewritten.
- R9: Edges arriving after a write was launched produce no further write until the request register is read. After that read, the next enabled edge launches a new write.
- R10: When an enabled edge and a request-register read fall in the same cycle, the read returns the older bits. The new bit survives the clear, and if a write had been sent it launches a new one.
- R11: An edge on a masked-off line, or any edge while control bit 0 is clear, produces no upstream write.
- R12: Reads of unmapped offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | 11 | Raw interrupt request lines |
| host_sel_i | input | 1 | Host access strobe |
| host_wr_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | 12 | Register byte offset |
| host_wdata_i | input | 32 | Write data |
| host_rdata_o | output | 32 | Read data, valid the cycle after the read |
| host_rvalid_o | output | 1 | Read data valid |
| up_valid_o | output | 1 | Upstream write request |
| up_ready_i | input | 1 | Upstream write accepted |
| up_addr_o | output | 32 | Upstream write address |
| up_data_o | output | 32 | Upstream write data |

## Verification
Two functions can meet in one cycle: the read-to-clear of the request register and the capture of a new synchronised edge. The bench first leaves one write delivered but not acknowledged. It then raises a second line exactly two clock edges before it presents the request read, so the edge detector fires in the read cycle. It judges the result three ways: the returned word must hold only the older bit, the new bit must still be readable afterwards, and a fresh upstream write must appear at once.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
    localparam int REG_AW = 12;
    localparam logic [REG_AW-1:0] OFS_TARGET = 12'h004;
    localparam logic [REG_AW-1:0] OFS_REQ    = 12'h00C;
    localparam logic [REG_AW-1:0] OFS_MASK   = 12'h018;
    localparam logic [REG_AW-1:0] OFS_PEND   = 12'h01C;
    localparam logic [REG_AW-1:0] OFS_CTRL   = 12'h024;
    localparam logic [REG_AW-1:0] OFS_LIVE   = 12'h028;

    typedef enum logic [1:0] {
        LS_IDLE = 2'd0,
        LS_SEND = 2'd1,
        LS_HOLD = 2'd2
    } launch_e;
endpackage

// File: rtl/msi_agg_sync.sv
module msi_agg_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.s1   = lines_i;
        d.s2   = q.s1;
        d.prev = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign level_o = q.s2;
    assign rise_o  = q.s2 & ~q.prev;
endmodule

// File: rtl/msi_agg_launch.sv
module msi_agg_launch
    import msi_agg_pkg::*;
#(
    parameter int DW = 32,
    parameter int VW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_i,
    input  logic          ack_i,
    input  logic [DW-1:0] target_i,
    input  logic          up_ready_i,
    output logic          up_valid_o,
    output logic [DW-1:0] up_addr_o,
    output logic [DW-1:0] up_data_o
);
    typedef struct packed {
        launch_e       state;
        logic          acked;
        logic [DW-1:0] addr;
        logic [DW-1:0] data;
    } launch_t;

    launch_t q, d;
    logic [DW-1:0] cap_addr, cap_data;

    assign cap_addr = {target_i[DW-1:VW], {VW{1'b0}}};
    assign cap_data = {{(DW-VW){1'b0}}, target_i[VW-1:0]};

    always_comb begin
        d = q;
        unique case (q.state)
            LS_IDLE: begin
                if (trig_i) begin
                    d.state = LS_SEND;
                    d.acked = 1'b0;
                    d.addr  = cap_addr;
                    d.data  = cap_data;
                end
            end
            LS_SEND: begin
                if (ack_i) d.acked = 1'b1;
                if (up_ready_i) begin
                    d.state = (q.acked || ack_i) ? LS_IDLE : LS_HOLD;
                    d.acked = 1'b0;
                end
            end
            LS_HOLD: begin
                if (ack_i) begin
                    if (trig_i) begin
                        d.state = LS_SEND;
                        d.addr  = cap_addr;
                        d.data  = cap_data;
                    end else begin
                        d.state = LS_IDLE;
                    end
                end
            end
            default: d.state = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign up_valid_o = (q.state == LS_SEND);
    assign up_addr_o  = q.addr;
    assign up_data_o  = q.data;

    p_valid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid_o && !up_ready_i) |=> up_valid_o);

    p_payload_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid_o && !up_ready_i) |=> ($stable(up_addr_o) && $stable(up_data_o)));

    p_launch_from_trig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_valid_o) |-> $past(trig_i));

    p_no_relaunch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == LS_HOLD && !ack_i) |=> !up_valid_o);
endmodule

// File: rtl/msi_agg.sv
module msi_agg
    import msi_agg_pkg::*;
#(
    parameter int                   NUM_LINES = 11,
    parameter logic [NUM_LINES-1:0] IMPL_MASK = 11'h5FF,
    parameter int                   DATA_W    = 32,
    parameter int                   VEC_W     = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  irq_lines_i,
    input  logic                  host_sel_i,
    input  logic                  host_wr_i,
    input  logic [REG_AW-1:0]     host_addr_i,
    input  logic [DATA_W-1:0]     host_wdata_i,
    output logic [DATA_W-1:0]     host_rdata_o,
    output logic                  host_rvalid_o,
    output logic                  up_valid_o,
    input  logic                  up_ready_i,
    output logic [DATA_W-1:0]     up_addr_o,
    output logic [DATA_W-1:0]     up_data_o
);
    typedef struct packed {
        logic [DATA_W-1:0]    target;
        logic                 deliver_en;
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] pend;
        logic [DATA_W-1:0]    rdata;
        logic                 rvalid;
    } regs_t;

    regs_t q, d;

    logic [NUM_LINES-1:0] level, rise, rise_impl, req_view, clr;
    logic                 rd_en, wr_en, rd_req, rd_pend, trig;

    msi_agg_sync #(.W(NUM_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (irq_lines_i),
        .level_o (level),
        .rise_o  (rise)
    );

    always_comb begin
        rd_en     = host_sel_i && !host_wr_i;
        wr_en     = host_sel_i && host_wr_i;
        rd_req    = rd_en && (host_addr_i == OFS_REQ);
        rd_pend   = rd_en && (host_addr_i == OFS_PEND);
        rise_impl = rise & IMPL_MASK;
        req_view  = q.pend & q.mask;
        trig      = q.deliver_en && ((rise_impl & q.mask) != '0);

        if (rd_req)       clr = req_view;
        else if (rd_pend) clr = '1;
        else              clr = '0;

        d        = q;
        d.pend   = (q.pend & ~clr) | rise_impl;
        d.rvalid = rd_en;

        if (wr_en) begin
            unique case (host_addr_i)
                OFS_TARGET: d.target     = host_wdata_i;
                OFS_MASK:   d.mask       = host_wdata_i[NUM_LINES-1:0] & IMPL_MASK;
                OFS_CTRL:   d.deliver_en = host_wdata_i[0];
                default:    ;
            endcase
        end

        if (rd_en) begin
            unique case (host_addr_i)
                OFS_TARGET: d.rdata = q.target;
                OFS_REQ:    d.rdata = DATA_W'(req_view);
                OFS_MASK:   d.rdata = DATA_W'(q.mask);
                OFS_PEND:   d.rdata = DATA_W'(q.pend);
                OFS_CTRL:   d.rdata = DATA_W'(q.deliver_en);
                OFS_LIVE:   d.rdata = DATA_W'(level);
                default:    d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    msi_agg_launch #(.DW(DATA_W), .VW(VEC_W)) u_launch (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (trig),
        .ack_i      (rd_req),
        .target_i   (q.target),
        .up_ready_i (up_ready_i),
        .up_valid_o (up_valid_o),
        .up_addr_o  (up_addr_o),
        .up_data_o  (up_data_o)
    );

    assign host_rdata_o  = q.rdata;
    assign host_rvalid_o = q.rvalid;

    p_req_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rise_impl == '0) |=> ((q.pend & q.mask) == '0));

    p_pend_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pend && rise_impl == '0) |=> (q.pend == '0));
endmodule

// File: tb/msi_agg_bench.sv
module msi_agg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] lines = '0;
    logic        sel = 1'b0, wr = 1'b0, ready = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, up_addr, up_data;
    logic        rvalid, up_valid;
    int          n_chk = 0, n_fail = 0;
    logic [31:0] v;

    always #5 clk = ~clk;

    msi_agg u_msi_agg (
        .clk(clk), .rst_n(rst_n), .irq_lines_i(lines),
        .host_sel_i(sel), .host_wr_i(wr), .host_addr_i(addr),
        .host_wdata_i(wdata), .host_rdata_o(rdata), .host_rvalid_o(rvalid),
        .up_valid_o(up_valid), .up_ready_i(ready),
        .up_addr_o(up_addr), .up_data_o(up_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [11:0] a, input logic [31:0] dv);
        @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = dv;
        @(posedge clk); #1; sel = 1'b0; wr = 1'b0;
    endtask

    task automatic host_read(input logic [11:0] a, output logic [31:0] dv);
        @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
        @(posedge clk); #1; sel = 1'b0;
        @(negedge clk); dv = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_line(input int idx, input logic lv);
        @(negedge clk); lines[idx] = lv;
    endtask

    task automatic wait_valid(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 12 && !seen; i++) begin
            @(negedge clk);
            if (up_valid) seen = 1'b1;
        end
    endtask

    task automatic accept();
        @(negedge clk); ready = 1'b1;
        @(negedge clk); ready = 1'b0;
    endtask

    task automatic no_write_for(input int n, input string tag);
        bit any = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (up_valid) any = 1'b1;
        end
        check(!any, tag, 32'(any), 32'h0);
    endtask

    task automatic t_reset();
        check(!up_valid, "R1 valid low", 32'(up_valid), 0);
        host_read(12'h004, v); check(v == 0, "R1 target", v, 0);
        host_read(12'h018, v); check(v == 0, "R1 mask", v, 0);
        host_read(12'h01C, v); check(v == 0, "R1 pending", v, 0);
        host_read(12'h024, v); check(v == 0, "R1 control", v, 0);
    endtask

    task automatic t_regmap();
        host_write(12'h004, 32'hABCD_1235);
        host_read(12'h004, v); check(v == 32'hABCD_1235, "R2 target", v, 32'hABCD_1235);
        host_write(12'h018, 32'hFFFF_FFFF);
        host_read(12'h018, v); check(v == 32'h5FF, "R2 mask", v, 32'h5FF);
        host_write(12'h024, 32'hFFFF_FFFF);
        host_read(12'h024, v); check(v == 1, "R2 control", v, 1);
        host_write(12'h100, 32'h1234_5678);
        host_read(12'h100, v); check(v == 0, "R12 unmapped read", v, 0);
        host_read(12'h004, v); check(v == 32'hABCD_1235, "R12 target untouched", v, 32'hABCD_1235);
        host_write(12'h024, 0);
        host_write(12'h018, 0);
    endtask

    task automatic t_live();
        @(negedge clk); lines = 11'h2A5; idle(4);
        host_read(12'h028, v); check(v == 32'h2A5, "R3 live", v, 32'h2A5);
        host_read(12'h028, v); check(v == 32'h2A5, "R3 live reread", v, 32'h2A5);
        @(negedge clk); lines = '0; idle(4);
        host_read(12'h028, v); check(v == 0, "R3 live low", v, 0);
        host_read(12'h01C, v);
    endtask

    task automatic t_pending();
        @(negedge clk); lines = 11'h208; idle(5);
        host_read(12'h01C, v); check(v == 32'h8, "R4 pending no line9", v, 32'h8);
        host_read(12'h01C, v); check(v == 0, "R6 pending cleared", v, 0);
        host_read(12'h028, v); check(v == 32'h208, "R6 live kept", v, 32'h208);
        @(negedge clk); lines = '0; idle(4);
    endtask

    task automatic t_request();
        host_write(12'h018, 32'h001);
        @(negedge clk); lines = 11'h005; idle(5);
        check(!up_valid, "R11 delivery off", 32'(up_valid), 0);
        host_read(12'h00C, v); check(v == 1, "R5 request", v, 1);
        host_read(12'h00C, v); check(v == 0, "R5 request cleared", v, 0);
        host_read(12'h01C, v); check(v == 4, "R5 masked bit kept", v, 4);
        @(negedge clk); lines = '0; idle(4);
    endtask

    task automatic t_deliver();
        bit seen;
        host_write(12'h004, 32'h8000_1236);
        host_write(12'h018, 32'h5FF);
        host_write(12'h024, 1);
        set_line(4, 1'b1);
        wait_valid(seen);
        check(seen, "R7 write launched", 32'(seen), 1);
        check(up_addr == 32'h8000_1220, "R7 address", up_addr, 32'h8000_1220);
        check(up_data == 32'h16, "R7 data", up_data, 32'h16);
        host_write(12'h004, 32'h4444_4441);
        idle(2);
        check(up_valid, "R8 valid held", 32'(up_valid), 1);
        check(up_addr == 32'h8000_1220, "R8 address stable", up_addr, 32'h8000_1220);
        accept();
        check(!up_valid, "R8 valid dropped", 32'(up_valid), 0);
        host_read(12'h00C, v); check(v == 32'h10, "R7 request bit", v, 32'h10);
        no_write_for(8, "R7 held line no rewrite");
        set_line(4, 1'b0);
        host_write(12'h004, 32'h8000_1236);
    endtask

    task automatic t_merge();
        bit seen;
        set_line(5, 1'b1);
        wait_valid(seen); check(seen, "R9 first write", 32'(seen), 1);
        accept();
        set_line(6, 1'b1);
        no_write_for(8, "R9 merged edge");
        host_read(12'h00C, v); check(v == 32'h60, "R9 merged request", v, 32'h60);
        no_write_for(5, "R9 no write without edge");
        set_line(7, 1'b1);
        wait_valid(seen); check(seen, "R9 write after ack", 32'(seen), 1);
        accept();
        host_read(12'h00C, v); check(v == 32'h80, "R9 second request", v, 32'h80);
    endtask

    task automatic t_masked();
        host_write(12'h018, 32'h4FF);
        set_line(8, 1'b1);
        no_write_for(8, "R11 masked line");
        host_read(12'h00C, v); check(v == 0, "R11 request empty", v, 0);
        host_read(12'h01C, v); check(v == 32'h100, "R11 pending seen", v, 32'h100);
        host_write(12'h018, 32'h5FF);
        @(negedge clk); lines = '0; idle(4);
        host_read(12'h01C, v);
    endtask

    task automatic t_same_cycle();
        bit seen;
        set_line(0, 1'b1);
        wait_valid(seen); check(seen, "R10 setup write", 32'(seen), 1);
        accept();
        @(negedge clk); lines[1] = 1'b1;
        @(posedge clk); @(posedge clk);
        host_read(12'h00C, v);
        check(v == 1, "R10 read returns old bit", v, 1);
        check(up_valid, "R10 new write queued", 32'(up_valid), 1);
        accept();
        host_read(12'h00C, v); check(v == 2, "R10 new bit survived", v, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_regmap();
        t_live();
        t_pending();
        t_request();
        t_deliver();
        t_merge();
        t_masked();
        t_same_cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule